// File: doc/BRIEF.md
# PWM Fault Trip Handler

This block sits between a PWM action stage and the output pads and overrides the two PWM signals, A and B, when an external fault input goes active. Six active-low fault pins are brought into the clock domain through a two-flop synchroniser. Each pin can be armed separately for two kinds of latch. A one-shot latch holds until software clears it. A cycle-by-cycle latch releases itself at the next counter-zero strobe from the time base.

While either latch is set, or an armed fault is active at the synchroniser output, each output takes its own forced action: leave it unchanged, drive it high, drive it low, or float it. To float an output, the block deasserts that output's enable, and the data pin then carries no meaning. The state of each latch is visible on a flag pin, so a fault can be diagnosed. There is no data stream, so every pin is a plain control or status level.

Top module: `pwm_fault_trip`

## Requirements
- R1: After reset both flags are 0, `out_a_o`/`out_b_o` follow `pwm_a_i`/`pwm_b_i`, and both enables are 1.
- R2: The fault pins are active low. If a pin is low before rising edge E1 and it is armed in either mode, the outputs carry the forced action from edge E2 onward. The flag of each mode that arms it reads 1 after E3.
- R3: A set one-shot latch stays set until `sw_clear_i` is high at a rising edge while no armed one-shot fault is active. The latch then reads 0 after that edge.
- R4: The cycle-by-cycle latch clears at a rising edge where `ctr_zero_i` is 1 and no armed cycle-by-cycle fault is active. Without a zero strobe it holds.
- R5: If an armed cycle-by-cycle fault is still active when `ctr_zero_i` is 1, the cycle-by-cycle latch stays set for the following period.
- R6: The action code for each output is 2'b00 none (pass the raw signal), 2'b01 drive 1, 2'b10 drive 0, and 2'b11 float (enable 0, data don't-care). While forcing, the output's enable is 1 for every code other than 2'b11.
- R7: A fault pin that is armed in neither mode has no effect on the outputs or the flags.
- R8: While the one-shot latch is set, a counter-zero strobe does not release the forced action, and the one-shot flag stays 1.
- R9: `sw_clear_i` has no effect on the cycle-by-cycle latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_n_i | input | 6 | Fault pins, active low, asynchronous |
| os_arm_i | input | 6 | Arms each fault pin for the one-shot latch |
| cbc_arm_i | input | 6 | Arms each fault pin for the cycle-by-cycle latch |
| ctr_zero_i | input | 1 | Counter-equals-zero strobe from the time base |
| sw_clear_i | input | 1 | Software release of the one-shot latch |
| act_a_i | input | 2 | Forced action for output A |
| act_b_i | input | 2 | Forced action for output B |
| pwm_a_i | input | 1 | Raw A signal |
| pwm_b_i | input | 1 | Raw B signal |
| out_a_o | output | 1 | Final A value |
| oe_a_o | output | 1 | Output enable for A; 0 means float |
| out_b_o | output | 1 | Final B value |
| oe_b_o | output | 1 | Output enable for B; 0 means float |
| os_flag_o | output | 1 | One-shot latch state |
| cbc_flag_o | output | 1 | Cycle-by-cycle latch state |

## Verification
The properties assume that the arming masks, the action codes and the raw PWM levels change only between clock edges. They also take `ctr_zero_i` and `sw_clear_i` to be single-cycle strobes that are sampled synchronously. The bench drives every input on the falling edge and samples on the falling edge one or more cycles later. Each strobe lasts exactly one cycle. The bench sweeps every fault pin, both latch modes and all sixteen pairs of action codes. It changes the raw levels between scenarios, so a stuck pass-through or a wrongly forced value shows up.

// File: rtl/ftrip_pkg.sv
package ftrip_pkg;
  typedef enum logic [1:0] {
    FT_ACT_NONE = 2'b00,
    FT_ACT_HIGH = 2'b01,
    FT_ACT_LOW  = 2'b10,
    FT_ACT_HIZ  = 2'b11
  } ft_act_e;

  localparam int FT_N_OUT = 2;
endpackage

// File: rtl/ftrip_sync.sv
module ftrip_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_n_i,
  output logic [W-1:0] q_n_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '1;
    end else begin
      stg[0] <= d_n_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q_n_o = stg[STAGES-1];
endmodule

// File: rtl/ftrip_latch.sv
module ftrip_latch #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] fault_i,
  input  logic [W-1:0] arm_i,
  input  logic         release_i,
  output logic         hit_o,
  output logic         state_o
);
  logic state_q;

  assign hit_o = |(fault_i & arm_i);

  // a live armed fault wins over a release in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= 1'b0;
    else if (hit_o) state_q <= 1'b1;
    else if (release_i) state_q <= 1'b0;
  end

  assign state_o = state_q;
endmodule

// File: rtl/ftrip_force.sv
module ftrip_force
  import ftrip_pkg::*;
(
  input  logic    forced_i,
  input  ft_act_e act_i,
  input  logic    raw_i,
  output logic    pin_o,
  output logic    oe_o
);
  always_comb begin
    pin_o = raw_i;
    oe_o  = 1'b1;
    if (forced_i) begin
      unique case (act_i)
        FT_ACT_NONE: pin_o = raw_i;
        FT_ACT_HIGH: pin_o = 1'b1;
        FT_ACT_LOW:  pin_o = 1'b0;
        FT_ACT_HIZ: begin
          pin_o = 1'b0;
          oe_o  = 1'b0;
        end
        default: pin_o = raw_i;
      endcase
    end
  end
endmodule

// File: rtl/pwm_fault_trip.sv
module pwm_fault_trip
  import ftrip_pkg::*;
#(
  parameter int N_FAULT     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FAULT-1:0] flt_n_i,
  input  logic [N_FAULT-1:0] os_arm_i,
  input  logic [N_FAULT-1:0] cbc_arm_i,
  input  logic               ctr_zero_i,
  input  logic               sw_clear_i,
  input  logic [1:0]         act_a_i,
  input  logic [1:0]         act_b_i,
  input  logic               pwm_a_i,
  input  logic               pwm_b_i,
  output logic               out_a_o,
  output logic               oe_a_o,
  output logic               out_b_o,
  output logic               oe_b_o,
  output logic               os_flag_o,
  output logic               cbc_flag_o
);
  logic [N_FAULT-1:0] fault_n_s;
  logic [N_FAULT-1:0] fault_s;
  logic os_hit, cbc_hit, os_state, cbc_state, forced;

  ftrip_sync #(.W(N_FAULT), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_n_i(flt_n_i), .q_n_o(fault_n_s)
  );

  assign fault_s = ~fault_n_s;

  ftrip_latch #(.W(N_FAULT)) os_latch_i (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_s), .arm_i(os_arm_i),
    .release_i(sw_clear_i), .hit_o(os_hit), .state_o(os_state)
  );

  ftrip_latch #(.W(N_FAULT)) cbc_latch_i (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_s), .arm_i(cbc_arm_i),
    .release_i(ctr_zero_i), .hit_o(cbc_hit), .state_o(cbc_state)
  );

  // the one-shot latch keeps forcing after a zero strobe releases the other
  assign forced = os_state | cbc_state | os_hit | cbc_hit;

  logic [FT_N_OUT-1:0] raw_v, pin_v, oe_v;
  ft_act_e             act_v [FT_N_OUT];

  assign raw_v    = {pwm_b_i, pwm_a_i};
  assign act_v[0] = ft_act_e'(act_a_i);
  assign act_v[1] = ft_act_e'(act_b_i);

  for (genvar g = 0; g < FT_N_OUT; g++) begin : g_out
    ftrip_force force_i (
      .forced_i(forced), .act_i(act_v[g]), .raw_i(raw_v[g]),
      .pin_o(pin_v[g]), .oe_o(oe_v[g])
    );
  end

  assign out_a_o    = pin_v[0];
  assign oe_a_o     = oe_v[0];
  assign out_b_o    = pin_v[1];
  assign oe_b_o     = oe_v[1];
  assign os_flag_o  = os_state;
  assign cbc_flag_o = cbc_state;
endmodule

// File: rtl/pwm_fault_trip_chk.sv
module pwm_fault_trip_chk #(
  parameter int N_FAULT = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_FAULT-1:0] fault_s,
  input logic [N_FAULT-1:0] os_arm_i,
  input logic [N_FAULT-1:0] cbc_arm_i,
  input logic               ctr_zero_i,
  input logic               sw_clear_i,
  input logic [1:0]         act_a_i,
  input logic               pwm_a_i,
  input logic               out_a_o,
  input logic               oe_a_o,
  input logic               os_flag_o,
  input logic               cbc_flag_o
);
  logic os_live, cbc_live;
  assign os_live  = |(fault_s & os_arm_i);
  assign cbc_live = |(fault_s & cbc_arm_i);

  AST_OS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    os_live |=> os_flag_o); // R2
  AST_OS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (os_flag_o && !sw_clear_i) |=> os_flag_o); // R3
  AST_CBC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cbc_flag_o && ctr_zero_i && !cbc_live) |=> !cbc_flag_o); // R4
  AST_CBC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cbc_flag_o && (!ctr_zero_i || cbc_live)) |=> cbc_flag_o); // R5
  AST_HIZ_A: assert property (@(posedge clk) disable iff (!rst_n)
    ((os_flag_o || cbc_flag_o) && act_a_i == 2'b11) |-> !oe_a_o); // R6
  AST_PASS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!os_flag_o && !cbc_flag_o && !os_live && !cbc_live)
      |-> (out_a_o == pwm_a_i && oe_a_o)); // R7
endmodule

bind pwm_fault_trip pwm_fault_trip_chk #(.N_FAULT(N_FAULT)) chk_i (
  .clk(clk), .rst_n(rst_n), .fault_s(fault_s), .os_arm_i(os_arm_i),
  .cbc_arm_i(cbc_arm_i), .ctr_zero_i(ctr_zero_i), .sw_clear_i(sw_clear_i),
  .act_a_i(act_a_i), .pwm_a_i(pwm_a_i), .out_a_o(out_a_o), .oe_a_o(oe_a_o),
  .os_flag_o(os_flag_o), .cbc_flag_o(cbc_flag_o)
);

// File: tb/pwm_fault_trip_tb_top.sv
module pwm_fault_trip_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic [5:0] flt_n, os_arm, cbc_arm;
  logic       ctr_zero, sw_clear;
  logic [1:0] act_a, act_b;
  logic       pwm_a, pwm_b;
  logic       out_a, oe_a, out_b, oe_b, os_flag, cbc_flag;
  int checks = 0;
  int fails  = 0;

  pwm_fault_trip dut_i (
    .clk(clk), .rst_n(rst_n), .flt_n_i(flt_n), .os_arm_i(os_arm),
    .cbc_arm_i(cbc_arm), .ctr_zero_i(ctr_zero), .sw_clear_i(sw_clear),
    .act_a_i(act_a), .act_b_i(act_b), .pwm_a_i(pwm_a), .pwm_b_i(pwm_b),
    .out_a_o(out_a), .oe_a_o(oe_a), .out_b_o(out_b), .oe_b_o(oe_b),
    .os_flag_o(os_flag), .cbc_flag_o(cbc_flag)
  );

  function automatic logic [1:0] expect_one(bit forced, logic [1:0] act, logic raw);
    if (!forced) return {raw, 1'b1};
    case (act)
      2'b01:   return 2'b11;
      2'b10:   return 2'b01;
      2'b11:   return 2'b00;
      default: return {raw, 1'b1};
    endcase
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_pins(string tag, bit forced);
    logic [1:0] ea, eb;
    bit bad;
    ea = expect_one(forced, act_a, pwm_a);
    eb = expect_one(forced, act_b, pwm_b);
    bad = (oe_a !== ea[0]) || (ea[0] && out_a !== ea[1]) ||
          (oe_b !== eb[0]) || (eb[0] && out_b !== eb[1]);
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s pins a=%b/%b b=%b/%b expected a=%b/%b b=%b/%b",
               tag, out_a, oe_a, out_b, oe_b, ea[1], ea[0], eb[1], eb[0]);
    end
  endtask

  task automatic check_flags(string tag, bit eos, bit ecbc);
    checks++;
    if (os_flag !== eos || cbc_flag !== ecbc) begin
      fails++;
      $display("FAIL %s flags os=%b cbc=%b expected os=%b cbc=%b",
               tag, os_flag, cbc_flag, eos, ecbc);
    end
  endtask

  task automatic pulse_zero();
    ctr_zero = 1'b1; tick(1); ctr_zero = 1'b0;
  endtask

  task automatic pulse_clear();
    sw_clear = 1'b1; tick(1); sw_clear = 1'b0;
  endtask

  task automatic run_trip(int idx, bit oneshot, logic [1:0] aa, logic [1:0] ab);
    os_arm  = oneshot ? 6'(1 << idx) : 6'd0;
    cbc_arm = oneshot ? 6'd0 : 6'(1 << idx);
    act_a = aa; act_b = ab;
    pwm_a = aa[0] ^ idx[0]; pwm_b = ~ab[1];
    flt_n[idx] = 1'b0;
    tick(1); check_pins("R2 before sync", 1'b0);
    tick(1); check_pins("R2 forced", 1'b1);
    tick(1); check_flags("R2 latched", oneshot, !oneshot);
    flt_n = '1;
    tick(3);
    pwm_a = ~pwm_a; pwm_b = ~pwm_b;
    tick(1);
    check_pins(oneshot ? "R3 held" : "R4 held", 1'b1);
    if (oneshot) begin
      pulse_zero();
      check_pins("R8 zero keeps force", 1'b1);
      check_flags("R8 zero keeps os", 1'b1, 1'b0);
      pulse_clear();
      check_pins("R3 released", 1'b0);
      check_flags("R3 released", 1'b0, 1'b0);
    end else begin
      pulse_clear();
      check_flags("R9 clear ignored", 1'b0, 1'b1);
      pulse_zero();
      check_pins("R4 released", 1'b0);
      check_flags("R4 released", 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flt_n = '1; os_arm = '0; cbc_arm = '0;
    ctr_zero = 1'b0; sw_clear = 1'b0;
    act_a = 2'b01; act_b = 2'b11; pwm_a = 1'b0; pwm_b = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check_flags("R1 reset", 1'b0, 1'b0);
    check_pins("R1 reset", 1'b0);

    for (int idx = 0; idx < 6; idx++)
      for (int m = 0; m < 2; m++)
        for (int c = 0; c < 16; c++)
          run_trip(idx, m[0], c[3:2], c[1:0]);

    // R5: fault still active at the zero strobe keeps the latch
    os_arm = '0; cbc_arm = 6'b000100; act_a = 2'b10; act_b = 2'b01;
    flt_n[2] = 1'b0;
    tick(3);
    pulse_zero();
    check_flags("R5 zero while active", 1'b0, 1'b1);
    check_pins("R5 zero while active", 1'b1);
    flt_n = '1;
    tick(3);
    check_flags("R5 after fault drop", 1'b0, 1'b1);
    pulse_zero();
    check_flags("R5 next zero", 1'b0, 1'b0);

    // R3: clear while the one-shot fault is still active does not release
    os_arm = 6'b100000; cbc_arm = '0;
    flt_n[5] = 1'b0;
    tick(3);
    pulse_clear();
    check_flags("R3 clear during fault", 1'b1, 1'b0);
    flt_n = '1;
    tick(3);
    pulse_clear();
    check_flags("R3 clear after fault", 1'b0, 1'b0);

    // R7: unarmed pin
    os_arm = 6'b111110; cbc_arm = 6'b111110; act_a = 2'b11; act_b = 2'b10;
    flt_n[0] = 1'b0;
    for (int k = 0; k < 5; k++) begin
      pwm_a = k[0]; pwm_b = ~k[0];
      tick(1);
      check_pins("R7 unarmed pin", 1'b0);
      check_flags("R7 unarmed pin", 1'b0, 1'b0);
    end
    flt_n = '1;
    tick(2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule